// File: doc/BRIEF.md
# Condition Field Masked Test Reducer

This unit tests one 4-bit condition field against a per-bit expected pattern, restricted by a per-bit mask. Each selected bit is compared for equality with its own pattern bit, which gives a 4-bit match vector. The vector is then collapsed to one bit, either by OR ("any selected bit matches") or by AND ("every bit is selected and matches"). The reduction is chosen per operation.

The result can be delivered in three ways, chosen by an operation code:
- as a 0/1 value in a 64-bit integer word;
- as the raw match nibble in the low bits of that word;
- as a single-bit write into a 32-bit condition register, at a 5-bit target address.

A request enters on a valid/ready stream and the result leaves on a valid/ready stream one cycle later. The result is held in one output stage.

Back-pressure rules:
- `in_ready` is high whenever the output stage is empty, or whenever its contents are consumed in the same cycle.
- While `out_valid` is high and `out_ready` is low, every result output is frozen.

Top module: `crtr_unit`

## Requirements
- R1: `match_o[j] = mask_i[j] & (patt_i[j] == fld_i[j])` for j in 0..3. Port bit 3 carries field position 0 (LT), bit 2 carries GT, bit 1 carries EQ and bit 0 carries SO.
- R2: With `any_i`=1, `res_o` is the OR of the four match bits.
- R3: With `any_i`=0, `res_o` is the AND of the four match bits. A mask with any bit clear therefore yields 0.
- R4: An all-zero mask yields `res_o`=0 under both reductions.
- R5: Op 2'b00 (integer bit): `int_o[0]` equals `res_o` and `int_o[63:1]` is zero.
- R6: Op 2'b01 (integer nibble): `int_o[3:0]` equals `match_o` and `int_o[63:4]` is zero.
- R7: Op 2'b10 (register bit): `tgt_i[4:2]` selects one of eight fields and `tgt_i[1:0]` selects the bit within it, with 0 being the most significant bit of the field. Bit numbering of the 32-bit register is most-significant-first, so the written port bit is `31 - tgt_i`. `cr_o` equals `cr_i` with only that bit replaced by `res_o`, and `int_o` is zero.
- R8: For ops 2'b00, 2'b01 and 2'b11, `cr_o` equals `cr_i`. Op 2'b11 is reserved and gives `int_o` = 0.
- R9: A request accepted at a clock edge (`in_valid & in_ready`) appears with `out_valid`=1 after that edge. `in_ready = !out_valid | out_ready`.
- R10: While `out_valid`=1 and `out_ready`=0, `res_o`, `match_o`, `int_o` and `cr_o` hold their values and `in_ready` is 0.
- R11: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| fld_i | input | 4 | Condition field under test |
| mask_i | input | 4 | Per-bit test select |
| patt_i | input | 4 | Per-bit expected value |
| any_i | input | 1 | 1 = OR reduction, 0 = AND reduction |
| op_i | input | 2 | Delivery form (00 int bit, 01 int nibble, 10 register bit, 11 reserved) |
| tgt_i | input | 5 | Register bit address for op 10 |
| cr_i | input | 32 | Condition register before the write |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed |
| res_o | output | 1 | Reduced result |
| match_o | output | 4 | Per-bit match vector |
| int_o | output | 64 | Integer destination word |
| cr_o | output | 32 | Condition register after the write |

## Verification
The per-bit test is tried with several field, mask and pattern combinations:
- full matches;
- single mismatches in each position, which tell the bit ordering apart;
- inverted patterns, which show the compare is against the pattern rather than against 1;
- partial masks with all selected bits matching, which separate OR from AND because AND fails on the unselected bits;
- an empty mask, which must give 0 in both modes.

Register writes use targets at both ends and in the middle of the register, against all-ones and all-zeros backgrounds. This shows that exactly one bit changes and that it sits at the most-significant-first position.

The stream edge is tried with a stalled consumer and a queued second request.

// File: rtl/crtr_pkg.sv
package crtr_pkg;
  typedef enum logic [1:0] {
    OP_INT_BIT = 2'b00,
    OP_INT_NIB = 2'b01,
    OP_CR_BIT  = 2'b10,
    OP_RSVD    = 2'b11
  } crtr_op_e;
endpackage

// File: rtl/crtr_match.sv
module crtr_match #(
  parameter int FIELD_W = 4
) (
  input  logic [FIELD_W-1:0] fld_i,
  input  logic [FIELD_W-1:0] mask_i,
  input  logic [FIELD_W-1:0] patt_i,
  output logic [FIELD_W-1:0] match_o
);
  // one equality test per field bit, gated by its mask bit
  for (genvar j = 0; j < FIELD_W; j++) begin : g_bit
    assign match_o[j] = mask_i[j] & ~(patt_i[j] ^ fld_i[j]);
  end

  always_comb begin
    // R1: a bit never reports a match when it is masked out
    a_r1_masked_quiet: assert ((match_o & ~mask_i) == '0)
      else $error("R1 match outside mask");
  end
endmodule

// File: rtl/crtr_reduce.sv
module crtr_reduce #(
  parameter int FIELD_W = 4
) (
  input  logic [FIELD_W-1:0] match_i,
  input  logic               any_i,
  output logic               res_o
);
  logic or_r, and_r;
  assign or_r  = |match_i;
  assign and_r = &match_i;
  assign res_o = any_i ? or_r : and_r;

  always_comb begin
    // R4: no match bit set means a zero result in either mode
    a_r4_empty_zero: assert (!((match_i == '0) && res_o))
      else $error("R4 empty match gave one");
  end
endmodule

// File: rtl/crtr_place.sv
module crtr_place
  import crtr_pkg::*;
#(
  parameter int FIELD_W   = 4,
  parameter int CR_FIELDS = 8,
  parameter int INT_W     = 64,
  localparam int CR_W     = FIELD_W * CR_FIELDS,
  localparam int IDX_W    = $clog2(CR_W)
) (
  input  crtr_op_e            op_i,
  input  logic                res_i,
  input  logic [FIELD_W-1:0]  match_i,
  input  logic [IDX_W-1:0]    tgt_i,
  input  logic [CR_W-1:0]     cr_i,
  output logic [INT_W-1:0]    int_o,
  output logic [CR_W-1:0]     cr_o
);
  logic cr_wr;
  assign cr_wr = (op_i == OP_CR_BIT);

  always_comb begin
    int_o = '0;
    unique case (op_i)
      OP_INT_BIT: int_o[0] = res_i;
      OP_INT_NIB: int_o[FIELD_W-1:0] = match_i;
      default:    int_o = '0;
    endcase
  end

  // register bits are addressed most-significant-first
  for (genvar b = 0; b < CR_W; b++) begin : g_crbit
    localparam logic [IDX_W-1:0] MY_ADDR = IDX_W'(CR_W - 1 - b);
    assign cr_o[b] = (cr_wr && (tgt_i == MY_ADDR)) ? res_i : cr_i[b];
  end

  always_comb begin
    // R7: a register write changes at most one bit
    a_r7_single_bit: assert ($countones(cr_o ^ cr_i) <= 1)
      else $error("R7 more than one bit changed");
    // R8: other ops leave the register intact
    a_r8_cr_untouched: assert (cr_wr || (cr_o == cr_i))
      else $error("R8 register changed");
    // R5/R6: integer word never carries anything above the nibble
    a_r6_int_upper_zero: assert (int_o[INT_W-1:FIELD_W] == '0)
      else $error("R6 upper integer bits set");
  end
endmodule

// File: rtl/crtr_unit.sv
module crtr_unit
  import crtr_pkg::*;
#(
  parameter int FIELD_W   = 4,
  parameter int CR_FIELDS = 8,
  parameter int INT_W     = 64,
  localparam int CR_W     = FIELD_W * CR_FIELDS,
  localparam int IDX_W    = $clog2(CR_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FIELD_W-1:0] fld_i,
  input  logic [FIELD_W-1:0] mask_i,
  input  logic [FIELD_W-1:0] patt_i,
  input  logic               any_i,
  input  logic [1:0]         op_i,
  input  logic [IDX_W-1:0]   tgt_i,
  input  logic [CR_W-1:0]    cr_i,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               res_o,
  output logic [FIELD_W-1:0] match_o,
  output logic [INT_W-1:0]   int_o,
  output logic [CR_W-1:0]    cr_o
);
  logic [FIELD_W-1:0] m_c;
  logic               r_c;
  logic [INT_W-1:0]   i_c;
  logic [CR_W-1:0]    c_c;
  logic               take;

  crtr_match #(.FIELD_W(FIELD_W)) u_match (
    .fld_i(fld_i), .mask_i(mask_i), .patt_i(patt_i), .match_o(m_c)
  );

  crtr_reduce #(.FIELD_W(FIELD_W)) u_reduce (
    .match_i(m_c), .any_i(any_i), .res_o(r_c)
  );

  crtr_place #(.FIELD_W(FIELD_W), .CR_FIELDS(CR_FIELDS), .INT_W(INT_W)) u_place (
    .op_i(crtr_op_e'(op_i)), .res_i(r_c), .match_i(m_c), .tgt_i(tgt_i),
    .cr_i(cr_i), .int_o(i_c), .cr_o(c_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_o     <= 1'b0;
      match_o   <= '0;
      int_o     <= '0;
      cr_o      <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      res_o     <= r_c;
      match_o   <= m_c;
      int_o     <= i_c;
      cr_o      <= c_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9: an accepted request is presented on the next cycle
  a_r9_accept_next: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid)
    else $error("R9 accepted request not presented");

  // R10: a stalled result is frozen
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_o) && $stable(match_o)
                                   && $stable(int_o) && $stable(cr_o)))
    else $error("R10 stalled result moved");

  // R10: no acceptance while stalled
  a_r10_no_take_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready)
    else $error("R10 ready during stall");
endmodule

// File: tb/crtr_unit_tb.sv
module crtr_unit_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, any, out_valid, out_ready, res;
  logic [3:0] fld, mask, patt, match;
  logic [1:0] op;
  logic [4:0] tgt;
  logic [31:0] cr_in, cr_out;
  logic [63:0] int_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  crtr_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .fld_i(fld), .mask_i(mask), .patt_i(patt), .any_i(any), .op_i(op),
    .tgt_i(tgt), .cr_i(cr_in), .out_valid(out_valid), .out_ready(out_ready),
    .res_o(res), .match_o(match), .int_o(int_out), .cr_o(cr_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected values from the requirements, in field-position order (0 = LT)
  function automatic logic [3:0] exp_match(input logic [3:0] f, m, p);
    logic [3:0] r;
    for (int k = 0; k < 4; k++)
      r[3-k] = m[3-k] && (p[3-k] == f[3-k]);
    return r;
  endfunction

  function automatic logic exp_res(input logic [3:0] mv, input logic a);
    logic o = 1'b0, n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      o = o | mv[k];
      n = n & mv[k];
    end
    return a ? o : n;
  endfunction

  task automatic apply(input logic [3:0] f, m, p, input logic a, input logic [1:0] o,
                       input logic [4:0] t, input logic [31:0] c);
    @(negedge clk);
    fld = f; mask = m; patt = p; any = a; op = o; tgt = t; cr_in = c;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic full_check(input string tag, input logic [3:0] f, m, p, input logic a,
                            input logic [1:0] o, input logic [4:0] t, input logic [31:0] c);
    logic [3:0] em;
    logic er;
    logic [63:0] ei;
    logic [31:0] ec;
    em = exp_match(f, m, p);
    er = exp_res(em, a);
    ei = 64'd0;
    ec = c;
    if (o == 2'b00) ei[0] = er;
    if (o == 2'b01) ei[3:0] = em;
    if (o == 2'b10) ec[31 - t] = er;
    apply(f, m, p, a, o, t, c);
    chk({tag, " R9 valid"}, 64'(out_valid), 64'd1);
    chk({tag, " R1 match"}, 64'(match), 64'(em));
    chk({tag, (a ? " R2 or" : " R3 and")}, 64'(res), 64'(er));
    chk({tag, (o == 2'b01 ? " R6 int" : " R5 int")}, int_out, ei);
    chk({tag, (o == 2'b10 ? " R7 cr" : " R8 cr")}, 64'(cr_out), 64'(ec));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 out_valid", 64'(out_valid), 64'd0);
    chk("R11 in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_match_patterns;
    full_check("full", 4'b1010, 4'b1111, 4'b1010, 1'b0, 2'b01, 5'd0, 32'h0);
    full_check("lt_miss", 4'b0010, 4'b1111, 4'b1010, 1'b1, 2'b01, 5'd0, 32'h0);
    full_check("so_miss", 4'b1011, 4'b1111, 4'b1010, 1'b0, 2'b01, 5'd0, 32'h0);
    full_check("inv", 4'b0000, 4'b1111, 4'b1111, 1'b1, 2'b01, 5'd0, 32'h0);
    // R1: only masked GT and EQ positions match
    full_check("part", 4'b0110, 4'b0110, 4'b0110, 1'b0, 2'b01, 5'd0, 32'h0);
  endtask

  task automatic t_reductions;
    // R2/R3: one mismatch separates OR from AND
    full_check("red_or", 4'b1100, 4'b1111, 4'b1101, 1'b1, 2'b00, 5'd0, 32'h0);
    full_check("red_and", 4'b1100, 4'b1111, 4'b1101, 1'b0, 2'b00, 5'd0, 32'h0);
    // R3: partial mask with all selected bits matching still fails AND
    full_check("and_part", 4'b0111, 4'b0111, 4'b0111, 1'b0, 2'b00, 5'd0, 32'h0);
    chk("R3 partial mask and", 64'(res), 64'd0);
    full_check("and_full", 4'b0101, 4'b1111, 4'b0101, 1'b0, 2'b00, 5'd0, 32'h0);
    chk("R3 full mask and", 64'(res), 64'd1);
  endtask

  task automatic t_zero_mask;
    full_check("zm_or", 4'b1010, 4'b0000, 4'b1010, 1'b1, 2'b00, 5'd0, 32'h0);
    chk("R4 zero mask or", 64'(res), 64'd0);
    full_check("zm_and", 4'b1010, 4'b0000, 4'b1010, 1'b0, 2'b00, 5'd0, 32'h0);
    chk("R4 zero mask and", 64'(res), 64'd0);
  endtask

  task automatic t_cr_write;
    full_check("cr0", 4'b1111, 4'b1111, 4'b1111, 1'b0, 2'b10, 5'd0, 32'h0);
    chk("R7 tgt0 msb", 64'(cr_out), 64'h8000_0000);
    full_check("cr31", 4'b0000, 4'b1111, 4'b1111, 1'b1, 2'b10, 5'd31, 32'hFFFF_FFFF);
    chk("R7 tgt31 lsb", 64'(cr_out), 64'hFFFF_FFFE);
    // field 3, bit 1 (GT) -> address 13 -> port bit 18
    full_check("cr13", 4'b0001, 4'b0001, 4'b0001, 1'b1, 2'b10, 5'd13, 32'h1234_5678);
    chk("R7 tgt13", 64'(cr_out), 64'h1234_5678 | 64'h0004_0000);
  endtask

  task automatic t_unchanged;
    full_check("keep00", 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'b00, 5'd5, 32'hA5A5_0F0F);
    full_check("keep01", 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'b01, 5'd5, 32'hA5A5_0F0F);
    full_check("keep11", 4'b1111, 4'b1111, 4'b1111, 1'b1, 2'b11, 5'd5, 32'hA5A5_0F0F);
    chk("R8 reserved int zero", int_out, 64'd0);
  endtask

  task automatic t_stream;
    // R9: with no new request the stage drains after one cycle
    apply(4'b1111, 4'b1111, 4'b1111, 1'b1, 2'b00, 5'd0, 32'h0);
    @(posedge clk); #1;
    chk("R9 drained", 64'(out_valid), 64'd0);
    // R10: stall with a second request waiting
    @(negedge clk);
    fld = 4'b1111; mask = 4'b1111; patt = 4'b1111; any = 1'b1; op = 2'b00;
    tgt = 5'd0; cr_in = 32'h0; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk); #1;
    chk("R9 first held valid", 64'(out_valid), 64'd1);
    chk("R10 first result", int_out, 64'd1);
    patt = 4'b0000;
    #1;
    chk("R10 ready low", 64'(in_ready), 64'd0);
    @(posedge clk); #1;
    chk("R10 hold int", int_out, 64'd1);
    chk("R10 hold res", 64'(res), 64'd1);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk("R9 ready on consume", 64'(in_ready), 64'd1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk("R10 second result", int_out, 64'd0);
    chk("R9 second valid", 64'(out_valid), 64'd1);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    fld = '0; mask = '0; patt = '0; any = 1'b0; op = '0; tgt = '0; cr_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_match_patterns();
    t_reductions();
    t_zero_mask();
    t_cr_write();
    t_unchanged();
    t_stream();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule